// File: doc/BRIEF.md
# Two-Bit Hysteresis Branch Predictor

This block is a direct-mapped table of two-bit branch predictor entries. The fetch stage presents a branch address on the lookup port. In the same cycle, with no register in the path, the block returns whether that branch is expected to be taken. Later, once the branch resolves in the execute stage, the update port delivers the same address and the real direction. The selected entry then moves to a new state on the next clock edge.

The entry update does not count up and down by one. A weak entry that sees a taken branch jumps straight to strongly taken, and any not-taken outcome from a weak entry falls back to strongly not-taken. A strongly-taken entry drops only to the weak taken state on a miss, so it must be wrong twice in a row before its prediction flips. No tag is stored, so addresses that share index bits share an entry.

The four states are named as follows, with their two-bit codes:
- `ST_SNT` (00) is strongly not-taken.
- `ST_WNT` (01) is weakly not-taken.
- `ST_WT` (10) is weakly taken.
- `ST_ST` (11) is strongly taken.

The transitions are named as follows:
- `SNT_HOLD` is 00→00 on not-taken.
- `SNT_ARM` is 00→01 on taken.
- `WEAK_PROMOTE` is 01/10→11 on taken.
- `WEAK_DROP` is 01/10→00 on not-taken.
- `ST_HOLD` is 11→11 on taken.
- `ST_SOFTEN` is 11→10 on not-taken.

Top module: `hyst_predictor`

## Requirements
- R1: When reset is released, every entry holds `ST_SNT` (00), so every lookup returns not-taken.
- R2: The entry index is PC bits [log2(DEPTH)+1:2]. PC bits [1:0], and all bits above the index field, have no effect on which entry is used.
- R3: `lk_taken` is 1 exactly when the indexed entry is in `ST_WT` (10) or `ST_ST` (11), and it is produced combinationally from `lk_pc`.
- R4: From `ST_SNT` (00), a taken update moves the entry to `ST_WNT` (01), and a not-taken update leaves it at 00.
- R5: From `ST_WNT` (01) or `ST_WT` (10), a taken update moves the entry to `ST_ST` (11), and a not-taken update moves it to `ST_SNT` (00).
- R6: From `ST_ST` (11), a taken update leaves the entry at 11, and a not-taken update moves it to `ST_WT` (10).
- R7: When `up_valid` is 0, no entry changes. When `up_valid` is 1, only the entry selected by `up_pc` can change.
- R8: If a lookup and an update select the same entry in the same cycle, the lookup returns the prediction from the state before the update. The new state becomes visible after the clock edge.
- R9: An entry in `ST_ST` keeps predicting taken after one not-taken update. It predicts not-taken only after a second consecutive one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; entries update on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_pc | input | PC_W | Branch address for the lookup |
| lk_taken | output | 1 | Prediction for `lk_pc` (1 = taken) |
| up_valid | input | 1 | Update strobe |
| up_pc | input | PC_W | Branch address of the resolved branch |
| up_taken | input | 1 | Resolved direction (1 = taken) |

## Verification
A lookup and an update can select the same entry in one cycle, which is the read-during-write case. The bench uses a small table and steers about a quarter of the random update addresses onto the lookup index. It samples `lk_taken` just before the edge and compares it with the reference model's state from before that edge. The bench then looks at the same entry on the next cycle to confirm that the write took effect.

// File: rtl/hyst_pkg.sv
package hyst_pkg;

    typedef enum logic [1:0] {
        ST_SNT = 2'b00,
        ST_WNT = 2'b01,
        ST_WT  = 2'b10,
        ST_ST  = 2'b11
    } hyst_state_e;

    localparam hyst_state_e RESET_STATE = ST_SNT;

endpackage

// File: rtl/hyst_index.sv
module hyst_index #(
    parameter int PC_W = 32,
    parameter int IW   = 6
) (
    input  logic [PC_W-1:0] pc,
    output logic [IW-1:0]   idx
);
    // Byte offset of aligned instructions and all upper bits are dropped (R2).
    assign idx = pc[IW+1:2];

    logic unused_bits;
    assign unused_bits = ^{pc[PC_W-1:IW+2], pc[1:0]};
endmodule

// File: rtl/hyst_next.sv
module hyst_next
    import hyst_pkg::*;
(
    input  hyst_state_e cur,
    input  logic        taken,
    output hyst_state_e nxt
);
    always_comb begin
        unique case (cur)
            ST_SNT:        nxt = taken ? ST_WNT : ST_SNT;   // SNT_ARM / SNT_HOLD
            ST_WNT, ST_WT: nxt = taken ? ST_ST  : ST_SNT;   // WEAK_PROMOTE / WEAK_DROP
            ST_ST:         nxt = taken ? ST_ST  : ST_WT;    // ST_HOLD / ST_SOFTEN
            default:       nxt = ST_SNT;
        endcase
    end
endmodule

// File: rtl/hyst_entry.sv
module hyst_entry
    import hyst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        taken,
    output hyst_state_e state
);
    hyst_state_e nxt;

    hyst_next u_next (
        .cur   (state),
        .taken (taken),
        .nxt   (nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= RESET_STATE;
        else if (wr_en)
            state <= nxt;
    end
endmodule

// File: rtl/hyst_read.sv
module hyst_read
    import hyst_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IW    = 6
) (
    input  logic [DEPTH-1:0][1:0] tbl,
    input  logic [IW-1:0]         idx,
    output logic                  taken
);
    hyst_state_e sel;
    assign sel = hyst_state_e'(tbl[idx]);

    always_comb begin
        unique case (sel)
            ST_SNT, ST_WNT: taken = 1'b0;
            ST_WT,  ST_ST:  taken = 1'b1;
            default:        taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/hyst_predictor.sv
module hyst_predictor
    import hyst_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PC_W  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    localparam int IW = $clog2(DEPTH);

    logic [IW-1:0]         lk_idx;
    logic [IW-1:0]         up_idx;
    logic [DEPTH-1:0][1:0] st_q;

    hyst_index #(.PC_W(PC_W), .IW(IW)) u_lk_idx (.pc(lk_pc), .idx(lk_idx));
    hyst_index #(.PC_W(PC_W), .IW(IW)) u_up_idx (.pc(up_pc), .idx(up_idx));

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic        wr;
        hyst_state_e s;
        assign wr = up_valid && (up_idx == IW'(g));
        hyst_entry u_ent (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr),
            .taken (up_taken),
            .state (s)
        );
        assign st_q[g] = s;
    end

    hyst_read #(.DEPTH(DEPTH), .IW(IW)) u_read (
        .tbl   (st_q),
        .idx   (lk_idx),
        .taken (lk_taken)
    );
endmodule

// File: rtl/hyst_predictor_chk.sv
module hyst_predictor_chk #(
    parameter int DEPTH = 64,
    parameter int PC_W  = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [PC_W-1:0]       lk_pc,
    input logic                  lk_taken,
    input logic                  up_valid,
    input logic [PC_W-1:0]       up_pc,
    input logic                  up_taken,
    input logic [DEPTH-1:0][1:0] st
);
    localparam int IW = $clog2(DEPTH);

    logic [IW-1:0] li, ui;
    assign li = lk_pc[IW+1:2];
    assign ui = up_pc[IW+1:2];

    logic unused_chk;
    assign unused_chk = ^{lk_pc[PC_W-1:IW+2], lk_pc[1:0], up_pc[PC_W-1:IW+2], up_pc[1:0]};

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st == '0));

    a_r3_pred_map: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken == (st[li] == 2'b10 || st[li] == 2'b11));

    a_r4_from_snt: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && st[ui] == 2'b00) |=>
        st[$past(ui)] == ($past(up_taken) ? 2'b01 : 2'b00));

    a_r5_from_weak: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && (st[ui] == 2'b01 || st[ui] == 2'b10)) |=>
        st[$past(ui)] == ($past(up_taken) ? 2'b11 : 2'b00));

    a_r6_from_st: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && st[ui] == 2'b11) |=>
        st[$past(ui)] == ($past(up_taken) ? 2'b11 : 2'b10));

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(st));

    a_r7_one_entry: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> $countones(st ^ $past(st)) <= 2);
endmodule

bind hyst_predictor hyst_predictor_chk #(.DEPTH(DEPTH), .PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_pc    (lk_pc),
    .lk_taken (lk_taken),
    .up_valid (up_valid),
    .up_pc    (up_pc),
    .up_taken (up_taken),
    .st       (st_q)
);

// File: tb/test_hyst_predictor.sv
module test_hyst_predictor;
    localparam int DEPTH = 16;
    localparam int PC_W  = 32;
    localparam int IW    = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken;
    logic            up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic            up_taken = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    hyst_predictor #(.DEPTH(DEPTH), .PC_W(PC_W)) i_hyst_predictor (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;
    logic [1:0] ref_st [DEPTH];

    function automatic logic [IW-1:0] ix(logic [PC_W-1:0] pc);
        return pc[IW+1:2];
    endfunction

    function automatic logic [1:0] ref_next(logic [1:0] cur, logic t);
        case (cur)
            2'b00:   return t ? 2'b01 : 2'b00;
            2'b01,
            2'b10:   return t ? 2'b11 : 2'b00;
            default: return t ? 2'b11 : 2'b10;
        endcase
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: lk_taken actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check prediction before the edge, update model after it.
    task automatic cycle(logic v, logic [PC_W-1:0] upc, logic t, logic [PC_W-1:0] lpc, string req);
        @(negedge clk);
        up_valid = v; up_pc = upc; up_taken = t; lk_pc = lpc;
        #1;
        chk(req, lk_taken, ref_st[ix(lpc)][1]);
        @(posedge clk);
        if (v) ref_st[ix(upc)] = ref_next(ref_st[ix(upc)], t);
    endtask

    task automatic upd(logic [PC_W-1:0] pc, logic t, string req);
        cycle(1'b1, pc, t, pc, req);
    endtask

    task automatic look(logic [PC_W-1:0] pc, string req);
        cycle(1'b0, '0, 1'b0, pc, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual=hung expected=complete");
        finish_run();
    end

    initial begin
        logic [PC_W-1:0] a;
        int unsigned     seed;
        seed = $urandom(32'd1357);
        for (int i = 0; i < DEPTH; i++) ref_st[i] = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every entry not-taken after reset
        for (int i = 0; i < DEPTH; i++) look(PC_W'(i * 4), "R1");

        a = 32'h0000_1000;  // index 0
        // R4: SNT_HOLD then SNT_ARM (01 still predicts not-taken)
        upd(a, 1'b0, "R4"); look(a, "R4");
        upd(a, 1'b1, "R4"); look(a, "R4");
        // R5: WEAK_PROMOTE from 01
        upd(a, 1'b1, "R5"); look(a, "R5");
        // R9 / R6: one miss keeps taken, ST_HOLD, then two misses flip
        upd(a, 1'b0, "R9"); look(a, "R9");
        upd(a, 1'b1, "R6"); look(a, "R6");
        upd(a, 1'b0, "R9"); look(a, "R9");
        upd(a, 1'b0, "R9"); look(a, "R9");
        // R5: WEAK_DROP from 01, then arm again must stay not-taken
        upd(a, 1'b1, "R5"); upd(a, 1'b0, "R5");
        upd(a, 1'b1, "R5"); look(a, "R5");
        upd(a, 1'b1, "R5"); look(a, "R5");
        // R2: offset and upper bits ignored, neighbour index untouched
        look(a | 32'h3, "R2");
        look(a + DEPTH * 4, "R2");
        look(a | 32'hF000_0000, "R2");
        look(a + 4, "R2");
        // R7: idle update port with a not-taken outcome changes nothing
        cycle(1'b0, a, 1'b0, a, "R7");
        cycle(1'b0, a, 1'b0, a, "R7");
        look(a, "R7");
        // R8: same-entry read and write in one cycle returns old state
        cycle(1'b1, a, 1'b0, a, "R8");
        cycle(1'b1, a, 1'b0, a, "R8");
        look(a, "R8");

        // Random mix, with forced index collisions
        for (int n = 0; n < 3000; n++) begin
            logic [PC_W-1:0] lp, upc;
            logic            v, t;
            lp  = $urandom;
            upc = ($urandom_range(3) == 0) ? (lp ^ 32'h0001_0003) : $urandom;
            v   = ($urandom_range(4) != 0);
            t   = $urandom_range(1);
            cycle(v, upc, t, lp, (v && ix(upc) == ix(lp)) ? "R8" : "R3");
        end
        finish_run();
    end
endmodule